// File: doc/BRIEF.md
# Real-Time-Clock Control Register with Interrupt Request

This block holds the eight control bits of a real-time clock and generates the clock's active-low interrupt request. A host writes and reads the register over a simple strobe-and-data bus. Three single-cycle event pulses arrive from neighbouring logic: a periodic tick, an alarm match and an update-ended indication. Each pulse sets a sticky flag. A flag pulls the interrupt line low only while its own enable bit is set. One clear strobe drops all three flags together.

The block drives the update-inhibit, square-wave-enable, binary-data-mode, 24-hour and daylight-saving bits out to the timekeeping logic. It also exposes the flag vector to the status register that sits next to it. The control bits do not all react to reset in the same way. The active-low reset pin clears the four enable bits and the flags. The update-inhibit, data-mode, hour-format and daylight-saving bits keep their values through reset. The update-ended enable is also forced to zero whenever the update-inhibit bit goes from 0 to 1.

Top module: `rtc_ctrl_irq`

## Requirements
- R1: A host write stores wrData into the register, and rdData shows the stored value combinationally from the next clock edge onward. The bit layout is bit7 update-inhibit, bit6 periodic enable, bit5 alarm enable, bit4 update-ended enable, bit3 square-wave enable, bit2 binary mode, bit1 24-hour, bit0 daylight saving.
- R2: While rstN is low, bits 6..3 and all three flags are 0 and irqN is 1, with no clock edge needed. Bits 7, 2, 1 and 0 keep the values they had before reset.
- R3: A write that takes bit7 from 0 to 1 leaves bit4 at 0, whatever value was written to bit4. A write made while bit7 is already 1 stores bit4 as written.
- R4: An event pulse sets its flag at the next edge whether or not its enable is set. The flag then stays set until a clear strobe arrives. On eventFlags, bit0 is the periodic flag, bit1 the alarm flag and bit2 the update-ended flag.
- R5: irqN is 0 exactly when one of these holds: the periodic flag and bit6 are both set, the alarm flag and bit5 are both set, or the update-ended flag and bit4 are both set.
- R6: A clear strobe with no event pulse in the same cycle clears all flags at the next edge, and irqN then returns to 1.
- R7: An event pulse in the same cycle as the clear strobe leaves its own flag set. The other flags are cleared.
- R8: Clearing an enable bit releases irqN while the matching flag stays set.
- R9: updateInhibit, sqwEnable, binaryMode, hour24 and dstEnable follow register bits 7, 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset pin |
| wrEn | input | 1 | Host write strobe for the control register |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Current register value |
| periodicTick | input | 1 | Periodic event pulse |
| alarmMatch | input | 1 | Alarm match event pulse |
| updateDone | input | 1 | Update-ended event pulse |
| flagClr | input | 1 | Clears all event flags |
| eventFlags | output | 3 | Flags: bit0 periodic, bit1 alarm, bit2 update-ended |
| irqN | output | 1 | Active-low interrupt request |
| updateInhibit | output | 1 | Stops the time counters from advancing |
| sqwEnable | output | 1 | Square-wave output enable |
| binaryMode | output | 1 | 1 selects binary data, 0 selects BCD |
| hour24 | output | 1 | 1 selects 24-hour format |
| dstEnable | output | 1 | Daylight-saving adjustment enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the flag clear strobe and an event pulse. The stimulus table raises both together, once with a single source and once with all three. The check is that the pulsed flags survive, the other flags drop, and irqN follows the enables. The second pair is the update-inhibit rising edge and a write of the update-ended enable. A single write carries both bits at 1, and the readback must show bit4 cleared. A second identical write, made while bit7 is already 1, must then store bit4.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;

  localparam int BIT_SET  = 7;
  localparam int BIT_PIE  = 6;
  localparam int BIT_AIE  = 5;
  localparam int BIT_UIE  = 4;
  localparam int BIT_SQW  = 3;
  localparam int BIT_BIN  = 2;
  localparam int BIT_H24  = 1;
  localparam int BIT_DST  = 0;

  localparam int SRC_PER = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_UPD = 2;

  typedef struct packed {
    logic               wrCtrl;
    logic [REG_W-1:0]   wrValue;
    logic               setRise;
    logic [NUM_SRC-1:0] flagSet;
    logic               flagClr;
  } ctlStrobes_t;
endpackage

// File: rtl/rtcc_control.sv
module rtcc_control
  import rtcc_pkg::*;
(
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               curSet,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               clrIn,
  output ctlStrobes_t        strb
);
  logic setRising;

  always_comb begin
    setRising = wrEn && wrData[BIT_SET] && !curSet;
    strb.wrCtrl  = wrEn;
    strb.setRise = setRising;
    strb.wrValue = wrData;
    if (setRising) begin
      strb.wrValue[BIT_UIE] = 1'b0;
    end
    strb.flagSet = evtIn;
    strb.flagClr = clrIn;
  end
endmodule

// File: rtl/rtcc_datapath.sv
module rtcc_datapath
  import rtcc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  output logic [REG_W-1:0]   regVal,
  output logic [NUM_SRC-1:0] flags,
  output logic               irqN
);
  logic setBit, binBit, h24Bit, dstBit;
  logic pieBit, aieBit, uieBit, sqwBit;
  logic [NUM_SRC-1:0] enVec;

  always_ff @(posedge clk) begin
    if (strb.wrCtrl) begin
      setBit <= strb.wrValue[BIT_SET];
      binBit <= strb.wrValue[BIT_BIN];
      h24Bit <= strb.wrValue[BIT_H24];
      dstBit <= strb.wrValue[BIT_DST];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pieBit <= 1'b0;
      aieBit <= 1'b0;
      uieBit <= 1'b0;
      sqwBit <= 1'b0;
    end else if (strb.wrCtrl) begin
      pieBit <= strb.wrValue[BIT_PIE];
      aieBit <= strb.wrValue[BIT_AIE];
      uieBit <= strb.wrValue[BIT_UIE];
      sqwBit <= strb.wrValue[BIT_SQW];
    end
  end

  always_comb begin
    regVal          = '0;
    regVal[BIT_SET] = setBit;
    regVal[BIT_PIE] = pieBit;
    regVal[BIT_AIE] = aieBit;
    regVal[BIT_UIE] = uieBit;
    regVal[BIT_SQW] = sqwBit;
    regVal[BIT_BIN] = binBit;
    regVal[BIT_H24] = h24Bit;
    regVal[BIT_DST] = dstBit;
    enVec          = '0;
    enVec[SRC_PER] = pieBit;
    enVec[SRC_ALM] = aieBit;
    enVec[SRC_UPD] = uieBit;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[i] <= 1'b0;
      end else begin
        flags[i] <= (flags[i] && !strb.flagClr) || strb.flagSet[i];
      end
    end

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      flags[i] && !strb.flagClr |=> flags[i]); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.flagSet[i] |=> flags[i]); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
      strb.flagClr && !strb.flagSet[i] |=> !flags[i]); // R6
  end

  assign irqN = !(|(flags & enVec));

  AST_UIE_DROP_ON_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setBit) |-> !uieBit); // R3
  AST_RETAINED_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCtrl |=> $stable({setBit, binBit, h24Bit, dstBit})); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> regVal == $past(strb.wrValue)); // R1
endmodule

// File: rtl/rtc_ctrl_irq.sv
module rtc_ctrl_irq
  import rtcc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               periodicTick,
  input  logic               alarmMatch,
  input  logic               updateDone,
  input  logic               flagClr,
  output logic [NUM_SRC-1:0] eventFlags,
  output logic               irqN,
  output logic               updateInhibit,
  output logic               sqwEnable,
  output logic               binaryMode,
  output logic               hour24,
  output logic               dstEnable
);
  ctlStrobes_t        strb;
  logic [REG_W-1:0]   regVal;
  logic [NUM_SRC-1:0] evtVec;

  always_comb begin
    evtVec          = '0;
    evtVec[SRC_PER] = periodicTick;
    evtVec[SRC_ALM] = alarmMatch;
    evtVec[SRC_UPD] = updateDone;
  end

  rtcc_control uCtl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .curSet (regVal[BIT_SET]),
    .evtIn  (evtVec),
    .clrIn  (flagClr),
    .strb   (strb)
  );

  rtcc_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .regVal (regVal),
    .flags  (eventFlags),
    .irqN   (irqN)
  );

  assign rdData        = regVal;
  assign updateInhibit = regVal[BIT_SET];
  assign sqwEnable     = regVal[BIT_SQW];
  assign binaryMode    = regVal[BIT_BIN];
  assign hour24        = regVal[BIT_H24];
  assign dstEnable     = regVal[BIT_DST];

  AST_IRQ_ON_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlags[SRC_PER] && rdData[BIT_PIE]) || (eventFlags[SRC_ALM] && rdData[BIT_AIE])
    || (eventFlags[SRC_UPD] && rdData[BIT_UIE]) |-> !irqN); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> |eventFlags); // R5
  AST_INHIBIT_MIRRORS: assert property (@(posedge clk) disable iff (!rstN)
    updateInhibit == rdData[BIT_SET]); // R9
endmodule

// File: tb/tb_rtc_ctrl_irq.sv
module tb_rtc_ctrl_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic periodicTick = 1'b0, alarmMatch = 1'b0, updateDone = 1'b0, flagClr = 1'b0;
  logic [2:0] eventFlags;
  logic irqN, updateInhibit, sqwEnable, binaryMode, hour24, dstEnable;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  rtc_ctrl_irq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .periodicTick(periodicTick), .alarmMatch(alarmMatch), .updateDone(updateDone),
    .flagClr(flagClr), .eventFlags(eventFlags), .irqN(irqN),
    .updateInhibit(updateInhibit), .sqwEnable(sqwEnable), .binaryMode(binaryMode),
    .hour24(hour24), .dstEnable(dstEnable)
  );

  // {wr, data, evt[2:0] (bit0 periodic, bit1 alarm, bit2 update), clr, expRd, expFlags, expIrqN}
  typedef struct packed {
    logic       wr;
    logic [7:0] data;
    logic [2:0] evt;
    logic       clr;
    logic [7:0] expRd;
    logic [2:0] expFlags;
    logic       expIrqN;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h0F, 3'b000, 1'b0, 8'h0F, 3'b000, 1'b1}, // R1
    '{1'b0, 8'h00, 3'b001, 1'b0, 8'h0F, 3'b001, 1'b1}, // R4 flag without enable
    '{1'b1, 8'h4F, 3'b000, 1'b0, 8'h4F, 3'b001, 1'b0}, // R5 periodic enabled
    '{1'b0, 8'h00, 3'b000, 1'b1, 8'h4F, 3'b000, 1'b1}, // R6
    '{1'b0, 8'h00, 3'b010, 1'b0, 8'h4F, 3'b010, 1'b1}, // R4 alarm
    '{1'b1, 8'h6F, 3'b000, 1'b0, 8'h6F, 3'b010, 1'b0}, // R5 alarm enabled
    '{1'b0, 8'h00, 3'b010, 1'b1, 8'h6F, 3'b010, 1'b0}, // R7
    '{1'b1, 8'h4F, 3'b000, 1'b0, 8'h4F, 3'b010, 1'b1}, // R8
    '{1'b0, 8'h00, 3'b100, 1'b0, 8'h4F, 3'b110, 1'b1}, // R4 update
    '{1'b1, 8'h5F, 3'b000, 1'b0, 8'h5F, 3'b110, 1'b0}, // R5 update enabled
    '{1'b1, 8'hDF, 3'b000, 1'b0, 8'hCF, 3'b110, 1'b1}, // R3 rise clears bit4
    '{1'b1, 8'hDF, 3'b000, 1'b0, 8'hDF, 3'b110, 1'b0}, // R3 no rise keeps bit4
    '{1'b0, 8'h00, 3'b000, 1'b1, 8'hDF, 3'b000, 1'b1}, // R6
    '{1'b0, 8'h00, 3'b111, 1'b1, 8'hDF, 3'b111, 1'b0}, // R7 all sources
    '{1'b1, 8'h00, 3'b000, 1'b0, 8'h00, 3'b111, 1'b1}, // R8 all enables off
    '{1'b0, 8'h00, 3'b000, 1'b1, 8'h00, 3'b000, 1'b1}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stepCycle(input logic w, input logic [7:0] d, input logic [2:0] e, input logic c);
    @(negedge clk);
    wrEn = w; wrData = d;
    periodicTick = e[0]; alarmMatch = e[1]; updateDone = e[2];
    flagClr = c;
    @(posedge clk);
    #5;
    wrEn = 1'b0; periodicTick = 1'b0; alarmMatch = 1'b0; updateDone = 1'b0; flagClr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1;
    check("R2 reset enables", {24'd0, rdData[6:3]}, 32'd0);
    check("R2 reset flags", {29'd0, eventFlags}, 32'd0);
    check("R2 reset irq", {31'd0, irqN}, 32'd1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      stepCycle(VECS[i].wr, VECS[i].data, VECS[i].evt, VECS[i].clr);
      check($sformatf("R1 vec%0d rdData", i), {24'd0, rdData}, {24'd0, VECS[i].expRd});
      check($sformatf("R4 vec%0d flags", i), {29'd0, eventFlags}, {29'd0, VECS[i].expFlags});
      check($sformatf("R5 vec%0d irqN", i), {31'd0, irqN}, {31'd0, VECS[i].expIrqN});
    end

    // R9 output mirrors
    stepCycle(1'b1, 8'h8A, 3'b000, 1'b0);
    check("R9 outputs 8A", {27'd0, updateInhibit, sqwEnable, binaryMode, hour24, dstEnable},
          {27'd0, 5'b11010});
    stepCycle(1'b1, 8'h05, 3'b000, 1'b0);
    check("R9 outputs 05", {27'd0, updateInhibit, sqwEnable, binaryMode, hour24, dstEnable},
          {27'd0, 5'b00101});

    // R3 rise with all ones, then reset retention
    stepCycle(1'b1, 8'hFF, 3'b000, 1'b0);
    check("R3 write FF", {24'd0, rdData}, 32'hEF);
    stepCycle(1'b0, 8'h00, 3'b111, 1'b0);
    check("R4 flags before reset", {29'd0, eventFlags}, 32'd7);
    check("R5 irq before reset", {31'd0, irqN}, 32'd0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R2 async reset reg", {24'd0, rdData}, 32'h87);
    check("R2 async reset flags", {29'd0, eventFlags}, 32'd0);
    check("R2 async reset irq", {31'd0, irqN}, 32'd1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 after release reg", {24'd0, rdData}, 32'h87);
    check("R9 after release", {27'd0, updateInhibit, sqwEnable, binaryMode, hour24, dstEnable},
          {27'd0, 5'b10111});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule